// File: doc/BRIEF.md
# Snoop Address-Hold Invalidation Interface

This block sits between the address pads of a processor with a write-through on-chip cache and that cache's tag logic. An external bus master that wants to check the cache raises the address-hold input. One clock later the block withdraws the drive enables of the address pads, so the master can present an address on the upper lines. Data transfers that were already started keep running, because the hold has no effect on data-bus drive.

While hold is active, the master pulses the external snoop strobe. The block registers the line address from the upper address bits on that clock. On the next clock it sends a single-cycle invalidate request with that line address to the tag logic. The line size is fixed by the lowest sampled address bit, which is 16 bytes by default. The low word-select lines are never inputs and are not sampled.

The block also watches the master's side of the handshake. After a strobe, hold must stay asserted for a minimum number of clocks. A strobe that arrives while hold is low is a protocol error. Each of these two cases raises its own one-cycle flag.

Top module: `snoop_hold_ctrl`

## Requirements
- R1: When `addr_hold_i` is sampled 1 on a rising edge, every bit of `addr_oe_o` is 0 from that edge on.
- R2: When `addr_hold_i` is sampled 0 on a rising edge, every bit of `addr_oe_o` is 1 from that edge on.
- R3: R1 and R2 also apply while `rst_n` is low. Reset never overrides the hold input.
- R4: `dat_oe_o` always equals `dat_oe_req_i`, combinationally, whatever the value of `addr_hold_i`.
- R5: If `snoop_strobe_i` and `addr_hold_i` are both sampled 1 at edge k, then `inv_valid_o` is 1 for exactly the cycle after edge k+1, and `inv_line_o` then equals the value `snoop_line_i` (address bits ADDR_W-1 down to LINE_LSB) had at edge k.
- R6: Changes on `snoop_line_i` after the strobe edge do not alter the line address carried by the invalidate pulse.
- R7: If `snoop_strobe_i` is sampled 1 while `addr_hold_i` is 0, no invalidate pulse follows. `viol_orphan_o` is 1 for the one cycle after that edge.
- R8: With MIN_HOLD = 2, suppose a strobe is accepted at edge k. If `addr_hold_i` is sampled 0 at edge k+1, `viol_early_o` is 1 for the one cycle after edge k+1. If hold is released at edge k+2 or later, `viol_early_o` stays 0.
- R9: While `rst_n` (active-low, synchronous) is low, strobes are ignored. `inv_valid_o`, `viol_early_o` and `viol_orphan_o` read 0 after a reset edge, and no pulse from a strobe seen during reset appears afterwards.
- R10: Strobes accepted on consecutive edges give invalidate pulses on consecutive cycles, each carrying its own line address, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_hold_i | input | 1 | Address hold request from the external master |
| snoop_strobe_i | input | 1 | External snoop address strobe |
| snoop_line_i | input | ADDR_W-LINE_LSB | Upper address lines used as inputs during hold |
| dat_oe_req_i | input | 1 | Data-bus drive request from the bus sequencer |
| dat_oe_o | output | 1 | Data-bus drive enable to the pads |
| addr_oe_o | output | OE_GROUPS | Address pad drive enables, one per pad group |
| inv_valid_o | output | 1 | One-cycle invalidate request to the tag logic |
| inv_line_o | output | ADDR_W-LINE_LSB | Line address of the invalidate request |
| viol_early_o | output | 1 | Hold released too soon after a strobe |
| viol_orphan_o | output | 1 | Strobe sampled while hold was inactive |

## Verification
The pad enables and both violation flags are due one edge after the input that causes them. The invalidate pulse is due two edges after its strobe. The data enable passes through combinationally and is checked a moment after its input changes. The bench applies inputs at the falling edge and advances one rising edge at a time. It then reads the outputs at the next falling edge, so every check is tied to a known count of edges since the stimulus. For each check the bench works out from that count whether a result must be present or absent. The release sweep moves the hold drop across edges one to four after the strobe and checks the flag and the pulse on every edge in between.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

   typedef struct packed {
      logic early;
      logic orphan;
   } snoop_viol_t;

   function automatic int guard_bits(input int min_hold);
      return (min_hold <= 2) ? 1 : $clog2(min_hold);
   endfunction

endpackage

// File: rtl/snoop_hold_tracker.sv
module snoop_hold_tracker #(
   parameter int OE_GROUPS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 hold_i,
   output logic [OE_GROUPS-1:0] addr_oe_o
);

   // One enable flop per pad group, deliberately without reset.
   for (genvar g = 0; g < OE_GROUPS; g++) begin : g_oe
      always_ff @(posedge clk) begin
         addr_oe_o[g] <= !hold_i;
      end
   end

   assert_float_R1: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> (addr_oe_o == '0));

   assert_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_i |=> (&addr_oe_o));

   // R3: no reset qualifier on purpose, hold wins during reset
   assert_reset_float_R3: assert property (@(posedge clk)
      (!rst_n && hold_i) |=> (addr_oe_o == '0));

endmodule

// File: rtl/snoop_capture.sv
module snoop_capture #(
   parameter int LINE_W = 28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold_i,
   input  logic              strobe_i,
   input  logic [LINE_W-1:0] line_i,
   output logic              inv_valid_o,
   output logic [LINE_W-1:0] inv_line_o
);

   logic              accept;
   logic              cap_vld;
   logic [LINE_W-1:0] cap_line;

   assign accept = strobe_i && hold_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_vld     <= 1'b0;
         cap_line    <= '0;
         inv_valid_o <= 1'b0;
         inv_line_o  <= '0;
      end else begin
         cap_vld     <= accept;
         inv_valid_o <= cap_vld;
         if (accept)  cap_line   <= line_i;
         if (cap_vld) inv_line_o <= cap_line;
      end
   end

   assert_pulse_due_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_i && hold_i) |=> ##1 inv_valid_o);

   assert_pulse_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid_o && $past(rst_n, 2)) |-> $past(strobe_i && hold_i, 2));

   assert_no_orphan_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid_o && $past(rst_n, 2)) |-> $past(hold_i, 2));

endmodule

// File: rtl/snoop_proto_check.sv
module snoop_proto_check
   import snoop_pkg::*;
#(
   parameter int MIN_HOLD = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        hold_i,
   input  logic        strobe_i,
   output snoop_viol_t viol_o
);

   localparam int GUARD_W = guard_bits(MIN_HOLD);

   logic early_hit;
   logic orphan_hit;

   assign orphan_hit = strobe_i && !hold_i;

   if (MIN_HOLD > 1) begin : g_guard
      logic [GUARD_W-1:0] guard_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            guard_q <= '0;
         end else if (strobe_i && hold_i) begin
            guard_q <= GUARD_W'(MIN_HOLD - 1);
         end else if (guard_q != '0) begin
            guard_q <= guard_q - 1'b1;
         end
      end

      assign early_hit = (guard_q != '0) && !hold_i;

      assert_early_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (!hold_i && $past(rst_n) && $past(strobe_i && hold_i)) |=> viol_o.early);
   end else begin : g_no_guard
      assign early_hit = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         viol_o <= '0;
      end else begin
         viol_o.early  <= early_hit;
         viol_o.orphan <= orphan_hit;
      end
   end

   assert_orphan_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_i && !hold_i) |=> viol_o.orphan);

   assert_orphan_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_o.orphan && $past(rst_n)) |-> $past(strobe_i && !hold_i));

endmodule

// File: rtl/snoop_hold_ctrl.sv
module snoop_hold_ctrl
   import snoop_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int LINE_LSB  = 4,
   parameter int MIN_HOLD  = 2,
   parameter int OE_GROUPS = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       addr_hold_i,
   input  logic                       snoop_strobe_i,
   input  logic [ADDR_W-LINE_LSB-1:0] snoop_line_i,
   input  logic                       dat_oe_req_i,
   output logic                       dat_oe_o,
   output logic [OE_GROUPS-1:0]       addr_oe_o,
   output logic                       inv_valid_o,
   output logic [ADDR_W-LINE_LSB-1:0] inv_line_o,
   output logic                       viol_early_o,
   output logic                       viol_orphan_o
);

   localparam int LINE_W = ADDR_W - LINE_LSB;

   if (LINE_LSB < 1 || LINE_LSB >= ADDR_W) begin : g_bad_line
      $error("snoop_hold_ctrl: LINE_LSB out of range");
   end
   if (MIN_HOLD < 1) begin : g_bad_hold
      $error("snoop_hold_ctrl: MIN_HOLD must be at least 1");
   end
   if (OE_GROUPS < 1) begin : g_bad_groups
      $error("snoop_hold_ctrl: OE_GROUPS must be at least 1");
   end

   snoop_viol_t viol;

   // Data drive is never gated by the address hold.
   assign dat_oe_o = dat_oe_req_i;

   snoop_hold_tracker #(
      .OE_GROUPS (OE_GROUPS)
   ) u_tracker (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold_i    (addr_hold_i),
      .addr_oe_o (addr_oe_o)
   );

   snoop_capture #(
      .LINE_W (LINE_W)
   ) u_capture (
      .clk         (clk),
      .rst_n       (rst_n),
      .hold_i      (addr_hold_i),
      .strobe_i    (snoop_strobe_i),
      .line_i      (snoop_line_i),
      .inv_valid_o (inv_valid_o),
      .inv_line_o  (inv_line_o)
   );

   snoop_proto_check #(
      .MIN_HOLD (MIN_HOLD)
   ) u_check (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold_i   (addr_hold_i),
      .strobe_i (snoop_strobe_i),
      .viol_o   (viol)
   );

   assign viol_early_o  = viol.early;
   assign viol_orphan_o = viol.orphan;

   assert_data_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
      addr_hold_i |-> (dat_oe_o == dat_oe_req_i));

endmodule

// File: tb/snoop_hold_ctrl_bench.sv
module snoop_hold_ctrl_bench;

   localparam int ADDR_W    = 32;
   localparam int LINE_LSB  = 4;
   localparam int MIN_HOLD  = 2;
   localparam int OE_GROUPS = 2;
   localparam int LINE_W    = ADDR_W - LINE_LSB;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              addr_hold_i;
   logic              snoop_strobe_i;
   logic [LINE_W-1:0] snoop_line_i;
   logic              dat_oe_req_i;
   logic              dat_oe_o;
   logic [OE_GROUPS-1:0] addr_oe_o;
   logic              inv_valid_o;
   logic [LINE_W-1:0] inv_line_o;
   logic              viol_early_o;
   logic              viol_orphan_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   snoop_hold_ctrl #(
      .ADDR_W    (ADDR_W),
      .LINE_LSB  (LINE_LSB),
      .MIN_HOLD  (MIN_HOLD),
      .OE_GROUPS (OE_GROUPS)
   ) u_snoop_hold_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .addr_hold_i    (addr_hold_i),
      .snoop_strobe_i (snoop_strobe_i),
      .snoop_line_i   (snoop_line_i),
      .dat_oe_req_i   (dat_oe_req_i),
      .dat_oe_o       (dat_oe_o),
      .addr_oe_o      (addr_oe_o),
      .inv_valid_o    (inv_valid_o),
      .inv_line_o     (inv_line_o),
      .viol_early_o   (viol_early_o),
      .viol_orphan_o  (viol_orphan_o)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
   endtask

   localparam logic [OE_GROUPS-1:0] OE_ON  = '1;
   localparam logic [OE_GROUPS-1:0] OE_OFF = '0;

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; addr_hold_i = 1'b0; snoop_strobe_i = 1'b0;
      snoop_line_i = '0; dat_oe_req_i = 1'b0;
      @(negedge clk);
      step();
      chk("R3 reset, hold low drives", addr_oe_o, OE_ON);
      chk("R9 reset inv_valid", inv_valid_o, 0);
      chk("R9 reset viol_early", viol_early_o, 0);
      chk("R9 reset viol_orphan", viol_orphan_o, 0);

      // R3: hold during reset, plus a strobe that must be ignored (R9)
      addr_hold_i = 1'b1; snoop_strobe_i = 1'b1; snoop_line_i = 28'hABCDEF1;
      step();
      chk("R3 hold in reset floats", addr_oe_o, OE_OFF);
      snoop_strobe_i = 1'b0; addr_hold_i = 1'b0;
      step();
      chk("R3 release in reset drives", addr_oe_o, OE_ON);
      rst_n = 1'b1;
      for (int i = 0; i < 3; i++) begin
         step();
         chk("R9 strobe in reset ignored", inv_valid_o, 0);
         chk("R9 no flag from reset strobe", viol_orphan_o | viol_early_o, 0);
      end

      // R4: data enable pass-through under every hold/request combination
      for (int h = 0; h < 2; h++) begin
         for (int d = 0; d < 2; d++) begin
            addr_hold_i = h[0]; dat_oe_req_i = d[0];
            #1;
            chk("R4 data enable follows request", dat_oe_o, d[0]);
         end
      end
      addr_hold_i = 1'b0; dat_oe_req_i = 1'b0;
      step();

      // R1 / R2: hold runs of several lengths
      for (int n = 1; n <= 4; n++) begin
         addr_hold_i = 1'b1;
         for (int j = 0; j < n; j++) begin
            step();
            chk("R1 float under hold", addr_oe_o, OE_OFF);
         end
         addr_hold_i = 1'b0;
         step();
         chk("R2 drive after release", addr_oe_o, OE_ON);
      end

      // R5 / R6 / R8: release sweep after a strobe
      for (int d = 1; d <= 4; d++) begin
         logic [LINE_W-1:0] pat;
         pat = 28'h0A55A5C ^ (LINE_W'(d) * 28'h1111111);
         addr_hold_i = 1'b1;
         step();
         snoop_strobe_i = 1'b1; snoop_line_i = pat;
         step();
         chk("R5 no pulse on strobe edge", inv_valid_o, 0);
         snoop_strobe_i = 1'b0; snoop_line_i = ~pat;
         for (int j = 1; j <= 4; j++) begin
            addr_hold_i = (j < d);
            step();
            chk("R5 pulse timing", inv_valid_o, (j == 1));
            if (j == 1) chk("R6 captured line", inv_line_o, pat);
            chk("R8 early flag", viol_early_o, (j == 1 && d < MIN_HOLD));
            chk("R7 no orphan flag", viol_orphan_o, 0);
         end
         addr_hold_i = 1'b0;
         step();
      end

      // R7: strobe without hold
      addr_hold_i = 1'b0; snoop_strobe_i = 1'b1; snoop_line_i = 28'h1234567;
      step();
      chk("R7 orphan flag", viol_orphan_o, 1);
      chk("R7 no pulse yet", inv_valid_o, 0);
      snoop_strobe_i = 1'b0;
      step();
      chk("R7 orphan flag one cycle", viol_orphan_o, 0);
      chk("R7 no invalidate", inv_valid_o, 0);
      step();
      chk("R7 still no invalidate", inv_valid_o, 0);

      // R10: back-to-back strobes
      addr_hold_i = 1'b1; snoop_strobe_i = 1'b1; snoop_line_i = 28'h0000111;
      step();
      snoop_line_i = 28'hFFFF222;
      step();
      snoop_strobe_i = 1'b0; snoop_line_i = 28'h5555555;
      chk("R10 first pulse", inv_valid_o, 1);
      chk("R10 first line", inv_line_o, 28'h0000111);
      step();
      chk("R10 second pulse", inv_valid_o, 1);
      chk("R10 second line", inv_line_o, 28'hFFFF222);
      step();
      chk("R10 pulses end", inv_valid_o, 0);
      chk("R8 no early flag with long hold", viol_early_o, 0);
      addr_hold_i = 1'b0;
      step();
      chk("R2 drive after snoop", addr_oe_o, OE_ON);

      // R9: reset mid-snoop clears the pipeline
      addr_hold_i = 1'b1; snoop_strobe_i = 1'b1; snoop_line_i = 28'h0F0F0F0;
      step();
      snoop_strobe_i = 1'b0; rst_n = 1'b0;
      step();
      chk("R9 reset kills pending pulse", inv_valid_o, 0);
      chk("R3 hold kept in reset", addr_oe_o, OE_OFF);
      rst_n = 1'b1; addr_hold_i = 1'b0;
      step();
      chk("R9 no pulse after reset", inv_valid_o, 0);
      chk("R9 no early flag after reset", viol_early_o, 0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule